// File: doc/BRIEF.md
# Bit Timing and Data Recovery Loop

This block recovers bit timing and data from a two-level serial stream. The stream is the discriminator output of an FM receiver, already turned into one bit and oversampled by a faster sample clock. A numerically controlled phase accumulator advances once per sample by an increment. One full wrap of the accumulator equals one bit period at the selected nominal rate. Each transition on the input pulls the accumulator back towards the expected phase. The size of that pull is set by a right-shift coefficient.

Two coefficients are loaded from outside. A wide one snaps the loop onto the alternating start pattern, which toggles every bit and so gives a transition at every bit boundary. A narrow one only trims the phase slowly once bit sync has been reached, for example during later runs of the alternating pattern. A mode input chooses which coefficient is active. When the accumulator reaches the middle of a bit, the block samples the input and raises a strobe for one clock. Downstream frame logic takes each recovered bit on that strobe.

Top module: `bit_clock_recovery`

## Requirements
- R1: While reset is active and until the first enabled sample after release, the accumulator is zero, `bit_stb` and `bit_out` are low, and the acquisition coefficient is active. With a constant input, the first strobe therefore follows the 8th enabled sample (default parameters).
- R2: The increment is floor(2^16 x rate / SAMPLE_HZ). `rate_sel`=0 selects RATE_HI_HZ (10 kbit/s) and `rate_sel`=1 selects RATE_LO_HZ (8 kbit/s). At the default 160 kHz sample rate this gives strobe spacings of 16 samples and of 20 or 21 samples.
- R3: On an enabled sample with no input transition, the accumulator advances by exactly the selected increment, modulo 2^16.
- R4: `bit_stb` is never high on two consecutive clocks.
- R5: When the accumulator's top bit goes from 0 to 1 on an enabled sample, `bit_out` takes `rx_in` and `bit_stb` pulses. Once locked, the bits come out in the order they were sent.
- R6: On an enabled sample where `rx_in` differs from the previous enabled sample, the next accumulator value is acc + inc - (signed(acc) >>> shift). Transitions are expected at the wrap point.
- R7: `gain_sel` is registered on each enabled sample: 0 makes `acq_shift` active and 1 makes `trk_shift` active. With tracking shift 2, an edge that arrives 4 samples late moves the phase by only one sample, so the next strobe comes 5 samples after that edge.
- R8: When `sample_en` is low, the accumulator holds its value and no strobe is issued.
- R9: With an active shift of 0, an edge sets the accumulator to the increment, so the next strobe comes 8 samples after the edge (default parameters).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| sample_en | input | 1 | Qualifies one oversampled input sample |
| rx_in | input | 1 | Digitized discriminator output |
| rate_sel | input | 1 | 0: high nominal rate, 1: low nominal rate |
| gain_sel | input | 1 | 0: acquisition coefficient, 1: tracking coefficient |
| acq_shift | input | 3 | Acquisition right-shift coefficient |
| trk_shift | input | 3 | Tracking right-shift coefficient |
| bit_out | output | 1 | Last recovered bit |
| bit_stb | output | 1 | One-clock pulse when a new bit is recovered |

## Verification
The checker examines every clock. It confirms that the accumulator is cleared in reset, that it free-runs by the rate-selected increment between edges, that a zero-shift edge snaps the phase, that an idle `sample_en` freezes the phase and suppresses strobes, and that strobes are single-cycle. The bench scenarios show the rest: that bits recovered after the alternating preamble match the bits sent, the strobe spacings at both rates, and the edge-to-strobe distances. Those distances separate the acquisition gain from the tracking gain after a phase step, which no single-cycle property can show.

// File: rtl/bcr_pkg.sv
package bcr_pkg;

  typedef enum logic {
    GAIN_ACQ = 1'b0,
    GAIN_TRK = 1'b1
  } gain_e;

  // Accumulator increment for one sample: 2^width * rate / fs, truncated.
  function automatic longint unsigned calc_inc(input int unsigned width,
                                               input longint unsigned rate_hz,
                                               input longint unsigned fs_hz);
    longint unsigned full;
    full = 64'd1 << width;
    return (full * rate_hz) / fs_hz;
  endfunction

endpackage

// File: rtl/bcr_rst_sync.sv
module bcr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_ns = sync_q[1];
endmodule

// File: rtl/bcr_edge_det.sv
module bcr_edge_det (
  input  logic clk,
  input  logic rst_ns,
  input  logic sample_en,
  input  logic rx_in,
  output logic edge_hit
);
  logic prev_q, prev_d;

  always_comb begin
    prev_d   = sample_en ? rx_in : prev_q;
    edge_hit = sample_en & (rx_in ^ prev_q);
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) prev_q <= 1'b0;
    else         prev_q <= prev_d;
  end
endmodule

// File: rtl/bcr_nco.sv
module bcr_nco #(
  parameter int unsigned PHASE_W = 16,
  parameter int unsigned SHIFT_W = 3
) (
  input  logic               clk,
  input  logic               rst_ns,
  input  logic               sample_en,
  input  logic               edge_hit,
  input  logic [PHASE_W-1:0] inc,
  input  logic [SHIFT_W-1:0] shift,
  output logic [PHASE_W-1:0] phase,
  output logic               center_hit
);
  logic [PHASE_W-1:0]        acc_q, acc_d;
  logic signed [PHASE_W-1:0] err, corr;

  always_comb begin
    // Edges belong at the wrap point: the signed value is the phase error.
    err        = $signed(acc_q);
    corr       = err >>> shift;
    acc_d      = acc_q;
    center_hit = 1'b0;
    if (sample_en) begin
      acc_d = acc_q + inc;
      if (edge_hit) acc_d = acc_d - $unsigned(corr);
      center_hit = !acc_q[PHASE_W-1] && acc_d[PHASE_W-1];
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) acc_q <= '0;
    else         acc_q <= acc_d;
  end

  assign phase = acc_q;
endmodule

// File: rtl/bcr_sampler.sv
module bcr_sampler (
  input  logic clk,
  input  logic rst_ns,
  input  logic center_hit,
  input  logic rx_in,
  output logic bit_out,
  output logic bit_stb
);
  logic data_q, data_d, stb_q, stb_d;

  always_comb begin
    stb_d  = center_hit;
    data_d = center_hit ? rx_in : data_q;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      data_q <= 1'b0;
      stb_q  <= 1'b0;
    end else begin
      data_q <= data_d;
      stb_q  <= stb_d;
    end
  end

  assign bit_out = data_q;
  assign bit_stb = stb_q;
endmodule

// File: rtl/bit_clock_recovery.sv
module bit_clock_recovery #(
  parameter int unsigned     PHASE_W    = 16,
  parameter int unsigned     SHIFT_W    = 3,
  parameter longint unsigned SAMPLE_HZ  = 160000,
  parameter longint unsigned RATE_HI_HZ = 10000,
  parameter longint unsigned RATE_LO_HZ = 8000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sample_en,
  input  logic               rx_in,
  input  logic               rate_sel,
  input  logic               gain_sel,
  input  logic [SHIFT_W-1:0] acq_shift,
  input  logic [SHIFT_W-1:0] trk_shift,
  output logic               bit_out,
  output logic               bit_stb
);
  import bcr_pkg::*;

  localparam logic [PHASE_W-1:0] INC_HI = PHASE_W'(calc_inc(PHASE_W, RATE_HI_HZ, SAMPLE_HZ));
  localparam logic [PHASE_W-1:0] INC_LO = PHASE_W'(calc_inc(PHASE_W, RATE_LO_HZ, SAMPLE_HZ));

  logic               rst_ns;
  logic               edge_hit;
  logic               center_hit;
  logic [PHASE_W-1:0] phase;
  logic [PHASE_W-1:0] inc;
  logic [SHIFT_W-1:0] act_shift;
  gain_e              gain_q, gain_d;

  bcr_rst_sync u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_ns(rst_ns)
  );

  always_comb begin
    gain_d    = sample_en ? gain_e'(gain_sel) : gain_q;
    act_shift = (gain_q == GAIN_ACQ) ? acq_shift : trk_shift;
    inc       = rate_sel ? INC_LO : INC_HI;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) gain_q <= GAIN_ACQ;
    else         gain_q <= gain_d;
  end

  bcr_edge_det u_edge (
    .clk      (clk),
    .rst_ns   (rst_ns),
    .sample_en(sample_en),
    .rx_in    (rx_in),
    .edge_hit (edge_hit)
  );

  bcr_nco #(
    .PHASE_W(PHASE_W),
    .SHIFT_W(SHIFT_W)
  ) u_nco (
    .clk       (clk),
    .rst_ns    (rst_ns),
    .sample_en (sample_en),
    .edge_hit  (edge_hit),
    .inc       (inc),
    .shift     (act_shift),
    .phase     (phase),
    .center_hit(center_hit)
  );

  bcr_sampler u_smp (
    .clk       (clk),
    .rst_ns    (rst_ns),
    .center_hit(center_hit),
    .rx_in     (rx_in),
    .bit_out   (bit_out),
    .bit_stb   (bit_stb)
  );
endmodule

// File: rtl/bcr_checker.sv
module bcr_checker #(
  parameter int unsigned     PHASE_W    = 16,
  parameter int unsigned     SHIFT_W    = 3,
  parameter longint unsigned SAMPLE_HZ  = 160000,
  parameter longint unsigned RATE_HI_HZ = 10000,
  parameter longint unsigned RATE_LO_HZ = 8000
) (
  input logic               clk,
  input logic               rst_ns,
  input logic               sample_en,
  input logic               rate_sel,
  input logic               edge_hit,
  input logic [SHIFT_W-1:0] act_shift,
  input logic [PHASE_W-1:0] phase,
  input logic               bit_stb
);
  localparam logic [PHASE_W-1:0] EXP_HI = PHASE_W'(bcr_pkg::calc_inc(PHASE_W, RATE_HI_HZ, SAMPLE_HZ));
  localparam logic [PHASE_W-1:0] EXP_LO = PHASE_W'(bcr_pkg::calc_inc(PHASE_W, RATE_LO_HZ, SAMPLE_HZ));

  logic [PHASE_W-1:0] exp_inc;
  assign exp_inc = rate_sel ? EXP_LO : EXP_HI;

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_ns |=> (phase == '0) && !bit_stb); // R1

  AST_FREE_RUN: assert property (@(posedge clk) disable iff (!rst_ns)
    (sample_en && !edge_hit) |=> phase == PHASE_W'($past(phase) + $past(exp_inc))); // R3

  AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (!rst_ns)
    bit_stb |=> !bit_stb); // R4

  AST_SNAP_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_ns)
    (edge_hit && act_shift == '0) |=> phase == $past(exp_inc)); // R9

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_ns)
    !sample_en |=> $stable(phase)); // R8

  AST_IDLE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_ns)
    !sample_en |=> !bit_stb); // R8
endmodule

bind bit_clock_recovery bcr_checker #(
  .PHASE_W   (PHASE_W),
  .SHIFT_W   (SHIFT_W),
  .SAMPLE_HZ (SAMPLE_HZ),
  .RATE_HI_HZ(RATE_HI_HZ),
  .RATE_LO_HZ(RATE_LO_HZ)
) u_chk (
  .clk      (clk),
  .rst_ns   (rst_ns),
  .sample_en(sample_en),
  .rate_sel (rate_sel),
  .edge_hit (edge_hit),
  .act_shift(act_shift),
  .phase    (phase),
  .bit_stb  (bit_stb)
);

// File: tb/bit_clock_recovery_test.sv
module bit_clock_recovery_test;
  logic       clk = 1'b0;
  logic       rst_n, sample_en, rx_in, rate_sel, gain_sel;
  logic [2:0] acq_shift, trk_shift;
  logic       bit_out, bit_stb;

  int n_checks = 0;
  int n_fail   = 0;
  int wide_stb = 0;
  bit armed    = 1'b0;
  bit done     = 1'b0;
  bit prev_stb = 1'b0;
  logic exp_q[$];

  always #4 clk = ~clk; // 125 MHz

  bit_clock_recovery uut (
    .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .rx_in(rx_in),
    .rate_sel(rate_sel), .gain_sel(gain_sel), .acq_shift(acq_shift),
    .trk_shift(trk_shift), .bit_out(bit_out), .bit_stb(bit_stb)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Driver: holds one bit for a full period; queues it when it is payload.
  task automatic send_bit(input logic b, input bit push);
    @(negedge clk);
    rx_in = b;
    if (push) exp_q.push_back(b);
    repeat (15) @(negedge clk);
  endtask

  // Negedges until the next strobe is seen.
  task automatic gap(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!bit_stb && n < 1000);
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (bit_stb && prev_stb) wide_stb++;
    prev_stb = bit_stb;
    if (bit_stb && armed) begin
      if (exp_q.size() == 0) check(1'b0, "R5 unexpected strobe", 1, 0);
      else begin
        logic e;
        e = exp_q.pop_front();
        check(bit_out == e, "R5 recovered bit", int'(bit_out), int'(e));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int n;
    logic [31:0] pat;
    rst_n = 1'b0; sample_en = 1'b0; rx_in = 1'b0; rate_sel = 1'b0;
    gain_sel = 1'b0; acq_shift = 3'd0; trk_shift = 3'd2;
    repeat (5) @(negedge clk);
    check(bit_stb == 1'b0, "R1 strobe in reset", int'(bit_stb), 0);
    check(bit_out == 1'b0, "R1 data in reset", int'(bit_out), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    sample_en = 1'b1;
    gap(n);
    check(n == 8, "R1 first strobe after cleared phase", n, 8);

    // R2 / R3: free-running spacing at the high rate
    for (int i = 0; i < 3; i++) begin
      gap(n);
      check(n == 16, "R2 R3 high-rate strobe spacing", n, 16);
    end

    // R5: preamble then payload through the scoreboard
    for (int i = 0; i < 8; i++) send_bit(logic'(~i[0]), 1'b0);
    armed = 1'b1;
    pat = 32'hF0A3_9600;
    for (int i = 31; i >= 0; i--) send_bit(pat[i], 1'b1);
    armed = 1'b0;
    check(exp_q.size() == 0, "R5 all payload bits recovered", exp_q.size(), 0);

    // R2: low rate spacing, first gap after switching discarded
    @(negedge clk);
    rate_sel = 1'b1;
    gap(n);
    for (int i = 0; i < 3; i++) begin
      gap(n);
      check(n == 20 || n == 21, "R2 low-rate strobe spacing", n, 20);
    end

    // R8: no strobe while sample_en is low
    sample_en = 1'b0;
    n = 0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (bit_stb) n++;
    end
    check(n == 0, "R8 strobes while idle", n, 0);

    // R6 / R9: acquisition shift 0 snaps phase on an edge
    sample_en = 1'b1;
    rate_sel  = 1'b0;
    repeat (3) @(negedge clk);
    rx_in = ~rx_in;
    gap(n);
    check(n == 8, "R9 R6 edge-to-strobe with acquisition gain", n, 8);
    repeat (8) @(negedge clk);

    // R7: tracking shift 2 only trims a 4-sample late edge
    gain_sel = 1'b1;
    for (int i = 0; i < 4; i++) begin
      rx_in = ~rx_in;
      repeat (16) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    rx_in = ~rx_in;
    gap(n);
    check(n == 5, "R7 edge-to-strobe with tracking gain", n, 5);

    check(wide_stb == 0, "R4 strobe wider than one clock", wide_stb, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule